// File: doc/BRIEF.md
# Event timestamp capture unit

This unit records the moment at which an external event occurs. An input pin is brought into the clock domain by a two-stage synchroniser. It may optionally be passed through a digital glitch filter. An edge detector with selectable polarity then watches it. On a qualifying edge the unit copies the value of a free-running 16-bit counter, supplied from outside, into its stamp register. It also raises a pending flag. When the interrupt enable is set, a pending flag drives the interrupt request.

The stamp register has a second use. In the waveform mode codes in which the counting logic takes its period limit from this register, the pin is not watched. The register can then be loaded from the host interface. In those modes the pending flag marks the cycles in which the counter equals the loaded limit. Counting and waveform generation live elsewhere. This unit only sees the counter value and the 4-bit mode code.

Top module: `evcap_unit`

## Requirements
- R1: With the filter off, a pin change made before rising clock edge 1 is acted on at edge 3. The stamp takes the counter value present at edge 3, and the flag is still 0 before that edge.
- R2: The filter is enabled by control bit 0 (register address 0). The filtered level changes only after four successive equal synchronised samples. A pulse shorter than four cycles produces no capture. An accepted edge is acted on four cycles later than in R1.
- R3: Control bit 1 selects the capture edge: 1 selects rising, 0 selects falling. An edge of the other polarity captures nothing.
- R4: A capture loads the counter value into the stamp register and sets the pending flag.
- R5: The interrupt request is high exactly while the flag is 1 and control bit 2 (interrupt enable) is 1.
- R6: The flag is cleared by a write to address 1 with data bit 0 equal to 1, or by a one-cycle pulse on the acknowledge input. A write to address 1 with bit 0 equal to 0 leaves the flag unchanged.
- R7: For mode codes 8, 10, 12 and 14, the pin is ignored. The flag is set in every cycle in which the counter equals the stamp register.
- R8: A write to address 2 loads the stamp register only under the mode codes of R7. Under any other mode the write is ignored.
- R9: When a flag-setting condition and a clear (write or acknowledge) fall in the same cycle, the flag ends up set.
- R10: After reset, the control bits, the flag, the stamp register and the interrupt request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low reset |
| cnt_i | input | 16 | Current counter value |
| mode_i | input | 4 | Waveform mode code of the counting logic |
| pin_i | input | 1 | Asynchronous event pin |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address: 0 control, 1 flag clear, 2 stamp |
| wr_data_i | input | 16 | Host write data |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse, clears the flag |
| stamp_o | output | 16 | Stamp register |
| flag_o | output | 1 | Pending flag |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 3 | Control bits {irq enable, rising select, filter enable} |

## Verification
The pending flag can be set and cleared in the same cycle. A capture, or a counter match in the limit modes, can coincide with a host write-one-to-clear or with an acknowledge pulse. The bench derives the cycle in which the capture lands from the pin change and the pipeline depth. It places the clear write on that very edge, and in the limit modes it places an acknowledge on the cycle where the counter equals the limit. It then expects the flag to read 1 and the stamp to hold the counter value of that edge. A clear issued one cycle later, with no set condition, is expected to drop the flag.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    // Control register, bit 0 = filter enable, bit 1 = rising select,
    // bit 2 = interrupt enable.
    typedef struct packed {
        logic irq_en;
        logic rise_sel;
        logic filt_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Mode codes in which the stamp register serves as the counting limit
    // (8, 10, 12, 14): upper bit set, lowest bit clear.
    function automatic logic stamp_is_limit(input logic [3:0] mode);
        return mode[3] && !mode[0];
    endfunction

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign q_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/evcap_filter.sv
module evcap_filter #(
    parameter int TAPS = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [TAPS-1:0] hist;
        logic            level;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hist = {st_q.hist[TAPS-2:0], d_i};
        if (&st_d.hist)       st_d.level = 1'b1;
        else if (~|st_d.hist) st_d.level = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign q_o = en_i ? st_q.level : d_i;

    // R2: a level change is backed by four agreeing input samples
    generate
        if (TAPS == 4) begin : g_chk4
            a_r2_filter_agree: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                !$stable(st_q.level) |->
                    ($past(d_i, 1) == st_q.level) && ($past(d_i, 2) == st_q.level) &&
                    ($past(d_i, 3) == st_q.level) && ($past(d_i, 4) == st_q.level))
                else $error("a_r2_filter_agree");
        end
    endgenerate

endmodule

// File: rtl/evcap_edge.sv
module evcap_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sig_i,
    input  logic rise_i,
    output logic evt_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign evt_o = rise_i ? (sig_i && !st_q.prev) : (!sig_i && st_q.prev);

    // R3: an event follows a level change in the selected direction
    a_r3_edge_dir: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        evt_o |=> (st_q.prev == $past(rise_i)))
        else $error("a_r3_edge_dir");

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 4,
    parameter int ADDR_W      = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [3:0]        mode_i,
    input  logic              pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              irq_ack_i,
    output logic [CNT_W-1:0]  stamp_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic [2:0]        ctrl_o
);
    import evcap_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(2);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] stamp;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic pin_sync;
    logic pin_sel;
    logic edge_evt;
    logic limit_mode;
    logic cap_evt;
    logic limit_hit;
    logic flag_set;
    logic flag_clr;
    logic wr_ctrl;
    logic wr_clr;
    logic wr_stamp;

    evcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (pin_i),
        .q_o     (pin_sync)
    );

    evcap_filter #(.TAPS(FILT_TAPS)) u_filter (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (st_q.ctrl.filt_en),
        .d_i     (pin_sync),
        .q_o     (pin_sel)
    );

    evcap_edge u_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .sig_i   (pin_sel),
        .rise_i  (st_q.ctrl.rise_sel),
        .evt_o   (edge_evt)
    );

    always_comb begin
        limit_mode = stamp_is_limit(mode_i);
        wr_ctrl    = wr_en_i && (wr_addr_i == A_CTRL);
        wr_clr     = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[0];
        wr_stamp   = wr_en_i && (wr_addr_i == A_STAMP);
        cap_evt    = edge_evt && !limit_mode;
        limit_hit  = limit_mode && (cnt_i == st_q.stamp);
        flag_set   = cap_evt || limit_hit;
        flag_clr   = wr_clr || irq_ack_i;

        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);

        if (flag_set)      st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;

        if (cap_evt)                     st_d.stamp = cnt_i;
        else if (limit_mode && wr_stamp) st_d.stamp = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign stamp_o = st_q.stamp;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.flag && st_q.ctrl.irq_en;
    assign ctrl_o  = st_q.ctrl;

    // R4: a capture stores the counter value of its cycle and marks pending
    a_r4_stamp_copy: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cap_evt |=> (st_q.stamp == $past(cnt_i)) && st_q.flag)
        else $error("a_r4_stamp_copy");

    // R6: the flag only drops after a clear request
    a_r6_flag_fall: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(st_q.flag) |-> $past(flag_clr))
        else $error("a_r6_flag_fall");

    // R7: in limit modes the pin cannot move the stamp
    a_r7_pin_ignored: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (limit_mode && !wr_stamp) |=> $stable(st_q.stamp))
        else $error("a_r7_pin_ignored");

    // R8: outside limit modes only a capture moves the stamp
    a_r8_stamp_guard: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!limit_mode && !cap_evt) |=> $stable(st_q.stamp))
        else $error("a_r8_stamp_guard");

    // R9: set wins over clear
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (flag_set && flag_clr) |=> st_q.flag)
        else $error("a_r9_set_wins");

endmodule

// File: tb/evcap_unit_tb_top.sv
module evcap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = 16'h0100;
    logic [3:0]  mode_i = 4'd0;
    logic        pin_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = 2'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic        irq_ack_i = 1'b0;
    logic [15:0] stamp_o;
    logic        flag_o;
    logic        irq_o;
    logic [2:0]  ctrl_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    evcap_unit dut_i (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .cnt_i     (cnt_i),
        .mode_i    (mode_i),
        .pin_i     (pin_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .irq_ack_i (irq_ack_i),
        .stamp_o   (stamp_o),
        .flag_o    (flag_o),
        .irq_o     (irq_o),
        .ctrl_o    (ctrl_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance to the next falling edge; the counter moves by one each cycle
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_i = cnt_i + 16'd1;
        end
    endtask

    task automatic wr(input logic [1:0] addr, input logic [15:0] data);
        wr_en_i   = 1'b1;
        wr_addr_i = addr;
        wr_data_i = data;
        step(1);
        wr_en_i   = 1'b0;
    endtask

    function automatic logic [3:0] capture_mode(input logic [3:0] m);
        return (m[3] && !m[0]) ? (m ^ 4'd1) : m;
    endfunction

    // expected stamp for a pulse: which edge matches, plus pipeline latency
    function automatic logic [15:0] exp_stamp(input logic filt, input logic rise,
                                              input logic idle, input logic [15:0] cs,
                                              input logic [15:0] ce);
        logic [15:0] lat;
        lat = filt ? 16'd6 : 16'd2;
        return (rise == !idle) ? cs + lat : ce + lat;
    endfunction

    task automatic trial(input logic filt, input logic rise, input logic idle,
                         input int len, input logic [3:0] mode);
        logic [15:0] old, cs, ce, es;
        mode_i = mode;
        wr(2'd0, {13'd0, 1'b1, rise, filt});
        pin_i = idle;
        step(10);
        wr(2'd1, 16'd1);
        old = stamp_o;
        pin_i = !idle;
        cs = cnt_i;
        step(len);
        pin_i = idle;
        ce = cnt_i;
        step(10);
        if (filt && len < 4) begin
            check("R2 short pulse rejected flag", flag_o, 1'b0);
            check("R2 short pulse rejected stamp", stamp_o, old);
        end else begin
            es = exp_stamp(filt, rise, idle, cs, ce);
            check("R3 edge select flag", flag_o, 1'b1);
            check("R4 stamp value", stamp_o, es);
            check("R5 irq follows flag", irq_o, 1'b1);
        end
    endtask

    initial begin
        logic [15:0] c0, lim;
        void'($urandom(32'h5EED_0042));
        step(3);
        check("R10 reset flag", flag_o, 1'b0);
        check("R10 reset stamp", stamp_o, 16'd0);
        check("R10 reset ctrl", ctrl_o, 3'd0);
        check("R10 reset irq", irq_o, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R1 unfiltered latency, with R9 clear landing on the capture edge
        wr(2'd0, 16'b110);
        pin_i = 1'b0;
        step(10);
        wr(2'd1, 16'd1);
        pin_i = 1'b1;
        c0 = cnt_i;
        step(2);
        check("R1 flag not early", flag_o, 1'b0);
        wr(2'd1, 16'd1);
        check("R9 capture beats clear", flag_o, 1'b1);
        check("R1 stamp at third edge", stamp_o, c0 + 16'd2);
        check("R5 irq enabled", irq_o, 1'b1);
        wr(2'd0, 16'b010);
        check("R5 irq masked", irq_o, 1'b0);
        check("R5 flag kept when masked", flag_o, 1'b1);
        wr(2'd1, 16'd0);
        check("R6 write zero keeps flag", flag_o, 1'b1);
        wr(2'd1, 16'd1);
        check("R6 write one clears flag", flag_o, 1'b0);

        // R2 filtered latency
        wr(2'd0, 16'b111);
        check("R2 ctrl readback", ctrl_o, 3'b111);
        pin_i = 1'b0;
        step(10);
        wr(2'd1, 16'd1);
        pin_i = 1'b1;
        c0 = cnt_i;
        step(6);
        check("R2 flag not before delay", flag_o, 1'b0);
        step(1);
        check("R2 flag after delay", flag_o, 1'b1);
        check("R2 stamp delayed by four", stamp_o, c0 + 16'd6);
        irq_ack_i = 1'b1;
        step(1);
        irq_ack_i = 1'b0;
        check("R6 acknowledge clears flag", flag_o, 1'b0);

        // R8 write ignored outside limit modes
        mode_i = 4'd4;
        c0 = stamp_o;
        wr(2'd2, 16'hBEEF);
        check("R8 write ignored in mode 4", stamp_o, c0);

        // R7 / R8 limit mode 12
        mode_i = 4'd12;
        lim = cnt_i + 16'd2000;
        wr(2'd2, lim);
        check("R8 write accepted in mode 12", stamp_o, lim);
        wr(2'd0, 16'b110);
        step(2);
        wr(2'd1, 16'd1);
        pin_i = 1'b0;
        step(3);
        pin_i = 1'b1;
        step(10);
        check("R7 pin ignored flag", flag_o, 1'b0);
        check("R7 pin ignored stamp", stamp_o, lim);
        cnt_i = lim - 16'd1;
        step(1);
        check("R7 no flag before match", flag_o, 1'b0);
        irq_ack_i = 1'b1;
        step(1);
        irq_ack_i = 1'b0;
        check("R9 match beats acknowledge", flag_o, 1'b1);
        check("R7 flag on limit match", flag_o, 1'b1);
        irq_ack_i = 1'b1;
        step(1);
        irq_ack_i = 1'b0;
        check("R6 acknowledge after match", flag_o, 1'b0);

        // random pulses in capture modes, including the R3 opposite-edge cases
        for (int t = 0; t < 48; t++) begin
            trial(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                  1 + int'($urandom % 7), capture_mode(4'($urandom % 16)));
        end
        // directed filter boundaries
        trial(1'b1, 1'b1, 1'b0, 3, 4'd0);
        trial(1'b1, 1'b1, 1'b0, 4, 4'd0);
        trial(1'b1, 1'b0, 1'b1, 4, 4'd10 ^ 4'd1);
        trial(1'b0, 1'b0, 1'b0, 1, 4'd4);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule